// File: doc/BRIEF.md
# Hybrid Parallel-Prefix Binary Adder

This block adds two unsigned or two's-complement words and a carry-in in one combinational pass. Every bit position first forms a generate flag (both operand bits set) and a propagate flag (operand bits differ). The carry-in is folded into position zero as if it came from an extra lower position with generate equal to the carry-in and propagate zero. A parallel-prefix graph of combining cells then turns the position flags into group generates over every span [0,i]. Group generate [0,i] is the carry into bit i+1, and the last one is the carry-out. Each sum bit is the position propagate XOR its incoming carry.

A combining cell takes an upper pair and a lower pair. It returns (g_hi OR (p_hi AND g_lo), p_hi AND p_lo). The operator is associative, but the two operands must not be swapped. The graph topology is a parameter with three choices. The sparse tree for 16 bits uses 6 levels and 26 cells. The dense doubling network uses 4 levels and 49 cells. The default hybrid uses 5 levels and 32 cells: one pairing level, then doubling spans over the odd-indexed nodes only, then one level that fills in the even positions.

Top module: `prefix_adder`

## Requirements
- R1: With the default hybrid topology, {cout_o, sum_o} equals the (WIDTH+1)-bit value x_i + y_i + cin_i for any inputs.
- R2: With both operands zero, sum_o equals cin_i zero-extended and cout_o is 0.
- R3: When every bit position propagates (y_i equals the bitwise inverse of x_i), cout_o equals cin_i. In that case sum_o is all ones for cin_i = 0 and all zeros for cin_i = 1.
- R4: A carry generated at bit 0 travels through any run of propagating positions above it. For x_i = 1 and y_i = 2^n - 1, the result is 2^n, for every n from 1 to WIDTH.
- R5: Exchanging x_i and y_i leaves sum_o and cout_o unchanged.
- R6: For a width of 16, the hybrid graph has 5 levels and 32 cells, the sparse graph has 6 levels and 26 cells, and the dense graph has 4 levels and 49 cells.
- R7: The sparse topology (TOPO_BK) and the dense topology (TOPO_KS) give the same sum_o and cout_o as the hybrid for every input.
- R8: The carry into every bit b+1 equals g_b OR (p_b AND carry into b), with the carry into bit 0 equal to cin_i.
- R9: The largest case, all-ones plus all-ones plus a carry-in of 1, gives sum_o all ones and cout_o 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x_i | input | WIDTH | First operand |
| y_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum bits |
| cout_o | output | 1 | Carry out of the top bit |

## Verification
The adder has no registers, so every result is due in the same cycle its operands change. The bench applies new operands on a rising edge of its own clock and compares sum_o and cout_o on the following falling edge. By then the combinational network has settled, and no edge-ordering race can affect the comparison. Each stimulus goes to three instances, one per topology, and all three are compared with one expected value that the bench computes.

// File: rtl/prefix_adder_pkg.sv
package prefix_adder_pkg;

  typedef enum logic [1:0] {TOPO_BK, TOPO_KS, TOPO_HYB} topo_e;

  function automatic int num_levels(topo_e t, int w);
    int l;
    l = $clog2(w);
    case (t)
      TOPO_KS: num_levels = l;
      TOPO_BK: num_levels = 2 * l - 2;
      default: num_levels = l + 1;
    endcase
  endfunction

  // Lower-neighbour index combined into node i at level lvl; -1 means pass-through.
  function automatic int src_of(topo_e t, int w, int lvl, int i);
    int l, s, dl, sd;
    l = $clog2(w);
    src_of = -1;
    case (t)
      TOPO_KS: begin
        s = 1 << lvl;
        if (i >= s) src_of = i - s;
      end
      TOPO_BK: begin
        if (lvl <= l - 1) begin
          s = 1 << lvl;
          if ((i + 1) % (2 * s) == 0) src_of = i - s;
        end
        // down-sweep starts one level early, sharing it with the last up-sweep cell
        if (lvl >= l - 1 && src_of < 0) begin
          dl = 2 * l - 3 - lvl;
          sd = 1 << dl;
          if (((i + 1) % (2 * sd) == sd) && (i + 1 > 2 * sd)) src_of = i - sd;
        end
      end
      default: begin
        if (lvl == 0) begin
          if (i % 2 == 1) src_of = i - 1;
        end else if (lvl < l) begin
          s = 1 << lvl;
          if ((i % 2 == 1) && (i >= s + 1)) src_of = i - s;
        end else begin
          if ((i % 2 == 0) && (i >= 2)) src_of = i - 1;
        end
      end
    endcase
  endfunction

  function automatic int num_cells(topo_e t, int w);
    num_cells = 0;
    for (int lv = 0; lv < num_levels(t, w); lv++)
      for (int i = 0; i < w; i++)
        if (src_of(t, w, lv, i) >= 0) num_cells++;
  endfunction

endpackage

// File: rtl/adder_gp_stage.sv
module adder_gp_stage #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] g_o,
  output logic [WIDTH-1:0] p_o
);
  logic [WIDTH-1:0] g_raw;

  assign g_raw = x_i & y_i;
  assign p_o   = x_i ^ y_i;

  // carry-in acts as position -1 with pair (cin, 0), merged into bit 0
  assign g_o[0] = g_raw[0] | (p_o[0] & cin_i);
  if (WIDTH > 1) begin : g_upper
    assign g_o[WIDTH-1:1] = g_raw[WIDTH-1:1];
  end
endmodule

// File: rtl/adder_gp_cell.sv
module adder_gp_cell (
  input  logic g_hi_i,
  input  logic p_hi_i,
  input  logic g_lo_i,
  input  logic p_lo_i,
  output logic g_o,
  output logic p_o
);
  // order matters: the upper span's propagate gates the lower span's generate
  assign g_o = g_hi_i | (p_hi_i & g_lo_i);
  assign p_o = p_hi_i & p_lo_i;
endmodule

// File: rtl/adder_prefix_net.sv
module adder_prefix_net #(
  parameter int                     WIDTH = 16,
  parameter prefix_adder_pkg::topo_e TOPO = prefix_adder_pkg::TOPO_HYB
) (
  input  logic [WIDTH-1:0] g_i,
  input  logic [WIDTH-1:0] p_i,
  output logic [WIDTH-1:0] grp_g_o
);
  localparam int NLEV = prefix_adder_pkg::num_levels(TOPO, WIDTH);

  logic [WIDTH-1:0] gs [NLEV+1];
  logic [WIDTH-1:0] ps [NLEV+1];
  logic             p_top_unused;

  assign gs[0] = g_i;
  assign ps[0] = p_i;

  for (genvar lv = 0; lv < NLEV; lv++) begin : g_lvl
    for (genvar b = 0; b < WIDTH; b++) begin : g_node
      localparam int SRC = prefix_adder_pkg::src_of(TOPO, WIDTH, lv, b);
      if (SRC >= 0) begin : g_cell
        adder_gp_cell u_cell (
          .g_hi_i (gs[lv][b]),
          .p_hi_i (ps[lv][b]),
          .g_lo_i (gs[lv][SRC]),
          .p_lo_i (ps[lv][SRC]),
          .g_o    (gs[lv+1][b]),
          .p_o    (ps[lv+1][b])
        );
      end else begin : g_pass
        assign gs[lv+1][b] = gs[lv][b];
        assign ps[lv+1][b] = ps[lv][b];
      end
    end
  end

  assign grp_g_o      = gs[NLEV];
  assign p_top_unused = ^ps[NLEV];
endmodule

// File: rtl/adder_sum_stage.sv
module adder_sum_stage #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] p_i,
  input  logic [WIDTH:0]   carry_i,
  output logic [WIDTH-1:0] sum_o
);
  assign sum_o = p_i ^ carry_i[WIDTH-1:0];
endmodule

// File: rtl/prefix_adder.sv
module prefix_adder #(
  parameter int                     WIDTH = 16,
  parameter prefix_adder_pkg::topo_e TOPO = prefix_adder_pkg::TOPO_HYB
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  logic [WIDTH-1:0] g_w;
  logic [WIDTH-1:0] p_w;
  logic [WIDTH-1:0] grp_g_w;
  logic [WIDTH:0]   carry_w;

  adder_gp_stage #(.WIDTH(WIDTH)) u_gp (
    .x_i   (x_i),
    .y_i   (y_i),
    .cin_i (cin_i),
    .g_o   (g_w),
    .p_o   (p_w)
  );

  adder_prefix_net #(.WIDTH(WIDTH), .TOPO(TOPO)) u_net (
    .g_i     (g_w),
    .p_i     (p_w),
    .grp_g_o (grp_g_w)
  );

  // group generate over [0,i] is the carry into bit i+1
  assign carry_w = {grp_g_w, cin_i};

  adder_sum_stage #(.WIDTH(WIDTH)) u_sum (
    .p_i     (p_w),
    .carry_i (carry_w),
    .sum_o   (sum_o)
  );

  assign cout_o = carry_w[WIDTH];
endmodule

// File: rtl/prefix_adder_chk.sv
module prefix_adder_chk #(
  parameter int WIDTH = 16
) (
  input logic [WIDTH-1:0] x_i,
  input logic [WIDTH-1:0] y_i,
  input logic             cin_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             cout_o,
  input logic [WIDTH:0]   carry_w
);
  logic known;
  assign known = !$isunknown({x_i, y_i, cin_i});

  always_comb begin
    if (known) begin
      assert_sum_R1: assert ({cout_o, sum_o} ==
        ({1'b0, x_i} + {1'b0, y_i} + {{WIDTH{1'b0}}, cin_i}));
      if (x_i == '0 && y_i == '0) begin
        assert_zero_ops_R2: assert (!cout_o && sum_o == {{(WIDTH-1){1'b0}}, cin_i});
      end
      if ((x_i ^ y_i) == '1) begin
        assert_all_prop_R3: assert (cout_o == cin_i && sum_o == {WIDTH{~cin_i}});
      end
      for (int b = 0; b < WIDTH; b++) begin
        assert_carry_rec_R8: assert (carry_w[b+1] ==
          ((x_i[b] & y_i[b]) | ((x_i[b] ^ y_i[b]) & carry_w[b])));
      end
      assert_cin_pos_R8: assert (carry_w[0] == cin_i);
    end
  end
endmodule

bind prefix_adder prefix_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .x_i     (x_i),
  .y_i     (y_i),
  .cin_i   (cin_i),
  .sum_o   (sum_o),
  .cout_o  (cout_o),
  .carry_w (carry_w)
);

// File: tb/prefix_adder_tb_top.sv
module prefix_adder_tb_top;
  import prefix_adder_pkg::*;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] x, y;
  logic         cin;
  logic [W-1:0] s_hy, s_bk, s_ks;
  logic         c_hy, c_bk, c_ks;
  int           total = 0;
  int           bad = 0;

  always #2.5 clk = ~clk;

  prefix_adder #(.WIDTH(W), .TOPO(TOPO_HYB)) dut_i (
    .x_i(x), .y_i(y), .cin_i(cin), .sum_o(s_hy), .cout_o(c_hy));
  prefix_adder #(.WIDTH(W), .TOPO(TOPO_BK)) dut_bk (
    .x_i(x), .y_i(y), .cin_i(cin), .sum_o(s_bk), .cout_o(c_bk));
  prefix_adder #(.WIDTH(W), .TOPO(TOPO_KS)) dut_ks (
    .x_i(x), .y_i(y), .cin_i(cin), .sum_o(s_ks), .cout_o(c_ks));

  function automatic logic [W:0] ref_add(logic [W-1:0] a, logic [W-1:0] b, logic c);
    return {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
  endfunction

  task automatic chk(string req, logic [W:0] got, logic [W:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic chk_int(string req, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // apply on a rising edge, compare on the next falling edge
  task automatic apply(logic [W-1:0] a, logic [W-1:0] b, logic c, string req);
    logic [W:0] e;
    @(posedge clk);
    x = a; y = b; cin = c;
    @(negedge clk);
    e = ref_add(a, b, c);
    chk(req, {c_hy, s_hy}, e);
    chk("R7 bk", {c_bk, s_bk}, e);
    chk("R7 ks", {c_ks, s_ks}, e);
  endtask

  task automatic apply_swap(logic [W-1:0] a, logic [W-1:0] b, logic c);
    logic [W:0] first;
    apply(a, b, c, "R1");
    first = {c_hy, s_hy};
    apply(b, a, c, "R1");
    chk("R5 swap", {c_hy, s_hy}, first);
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    logic [W-1:0] r;
    seed = 32'h1bad_5eed;
    x = '0; y = '0; cin = 1'b0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R2 reset state", {c_hy, s_hy}, '0);

    // R6 graph sizes from the topology functions
    chk_int("R6 hyb levels", num_levels(TOPO_HYB, W), 5);
    chk_int("R6 hyb cells",  num_cells(TOPO_HYB, W), 32);
    chk_int("R6 bk levels",  num_levels(TOPO_BK, W), 6);
    chk_int("R6 bk cells",   num_cells(TOPO_BK, W), 26);
    chk_int("R6 ks levels",  num_levels(TOPO_KS, W), 4);
    chk_int("R6 ks cells",   num_cells(TOPO_KS, W), 49);

    apply('0, '0, 1'b0, "R2");
    apply('0, '0, 1'b1, "R2");

    // R3 all-propagate chains
    apply(16'h0000, 16'hffff, 1'b0, "R3");
    apply(16'h0000, 16'hffff, 1'b1, "R3");
    apply(16'haaaa, 16'h5555, 1'b1, "R3");
    for (int k = 0; k < 20; k++) begin
      r = W'($urandom(seed + k));
      apply(r, ~r, k[0], "R3");
    end

    // R4 carry from bit 0 through n propagating bits
    for (int n = 1; n <= W; n++) begin
      logic [W:0] m;
      m = (({{W{1'b0}}, 1'b1}) << n) - 1;
      apply(16'h0001, m[W-1:0], 1'b0, "R4");
      chk("R4 chain", {c_hy, s_hy}, ({{W{1'b0}}, 1'b1} << n));
    end
    // carry-in through propagate runs of every length
    for (int n = 0; n <= W; n++) begin
      logic [W:0] m;
      m = (({{W{1'b0}}, 1'b1}) << n) - 1;
      apply(m[W-1:0], '0, 1'b1, "R4 cin run");
    end

    apply(16'hffff, 16'hffff, 1'b1, "R9");
    chk("R9 max", {c_hy, s_hy}, 17'h1ffff);
    apply(16'h8000, 16'h8000, 1'b0, "R1 top gen");
    apply(16'h7fff, 16'h0001, 1'b0, "R1 signed wrap");

    // R5 operand exchange
    apply_swap(16'h1234, 16'hfedc, 1'b1);
    apply_swap(16'h00ff, 16'h0f0f, 1'b0);
    for (int k = 0; k < 50; k++)
      apply_swap(W'($urandom()), W'($urandom()), 1'($urandom()));

    // R1/R7 random
    for (int k = 0; k < 2000; k++)
      apply(W'($urandom()), W'($urandom()), 1'($urandom()), "R1 rand");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule